// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM

This block is a synchronous memory of 2048 words of 16 bits with two symmetric, independent ports, called left and right. Each port has an active-low select, an active-low output enable, a separate read/write control for each byte lane, an 11-bit address, a write-data bus, a read-data bus, one valid flag per lane and an active-low write-block input. Either port can reach any word, and both ports can act in the same clock.

In a single access a port can write one lane and read the other. A lane reads when its control is high. A lane writes when its control is low. Read data is registered and appears one cycle after the request. A lane that is not driving output shows a low valid flag and zero data, which stands in for a high-impedance byte. While a port's write-block input is low, every write on that port is dropped. Reads on that port still work.

Top module: `dual_port_byte_ram`

## Requirements
- R1: The store holds 2048 words of 16 bits. Either port can write any word through its 11-bit address, and either port can later read that word back.
- R2: A port whose select is high makes no access: nothing is written, and in the next cycle both of its valid flags are low.
- R3: With select low and the write-block input high, a lane whose read/write control is 0 stores that lane's write-data byte. In the next cycle that lane's valid flag is low.
- R4: With select low and output enable low, a lane whose control is 1 drives the stored byte and sets its valid flag in the next cycle. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R5: Output enable high stops all read output (both valid flags low next cycle), but writes on lanes whose control is 0 still happen.
- R6: The two lanes are independent. A lower-byte write and an upper-byte read in the same access leave the upper byte unchanged, and the read returns the upper byte as it was.
- R7: While a port's write-block input is low, its writes are discarded and memory is unchanged. Its reads are unaffected.
- R8: When both ports write the same lane of the same word in one cycle, the left data is stored. Writes from the two ports to different lanes of one word both land.
- R9: A read of a word that the other port writes in the same cycle returns the old data.
- R10: Reset clears all valid flags and read data to zero. Reset does not clear memory contents.
- R11: Any lane whose valid flag is low shows zero on its read-data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| l_sel_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rw_lo | input | 1 | Left lane 0 control, 1 = read, 0 = write |
| l_rw_hi | input | 1 | Left lane 1 control, 1 = read, 0 = write |
| l_busy_n | input | 1 | Left write block, active low |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, registered |
| l_rvalid | output | 2 | Left per-lane valid flags |
| r_sel_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rw_lo | input | 1 | Right lane 0 control, 1 = read, 0 = write |
| r_rw_hi | input | 1 | Right lane 1 control, 1 = read, 0 = write |
| r_busy_n | input | 1 | Right write block, active low |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, registered |
| r_rvalid | output | 2 | Right per-lane valid flags |

## Verification
A write on one port and an access by the other port to the same word can land in the same clock. The bench provokes this in three ways. It writes the same lane from both ports to judge left priority. It writes opposite lanes from the two ports to check that both bytes merge. It reads on the right while the left writes the same word, and the read must show the old word. A read of each word in the following cycle then confirms what was stored.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int WORD_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int DEPTH  = 2048;
    localparam int ADDR_W = $clog2(DEPTH);

    // per-lane command after decode of one port's controls
    typedef struct packed {
        logic [LANES-1:0] we;
        logic [LANES-1:0] re;
    } lane_cmd_t;

    // rw bit: 1 = read lane, 0 = write lane
    function automatic lane_cmd_t decode_cmd(
        input logic             sel_n,
        input logic             oe_n,
        input logic             busy_n,
        input logic [LANES-1:0] rw
    );
        lane_cmd_t c;
        for (int i = 0; i < LANES; i++) begin
            c.we[i] = !sel_n && !rw[i] && busy_n;
            c.re[i] = !sel_n &&  rw[i] && !oe_n;
        end
        return c;
    endfunction

endpackage

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
    import dpram_pkg::*;
(
    input  logic             sel_n,
    input  logic             oe_n,
    input  logic             busy_n,
    input  logic [LANES-1:0] rw,
    output lane_cmd_t        cmd
);

    always_comb begin
        cmd = decode_cmd(sel_n, oe_n, busy_n, rw);
    end

endmodule

// File: rtl/dpram_lane_bank.sv
module dpram_lane_bank #(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [LANE_W-1:0] l_wbyte,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [LANE_W-1:0] r_wbyte,
    output logic [LANE_W-1:0] l_rbyte,
    output logic              l_rvld,
    output logic [LANE_W-1:0] r_rbyte,
    output logic              r_rvld
);

    logic [LANE_W-1:0] store [DEPTH];

    // right first, left last: left wins a same-word collision
    always_ff @(posedge clk) begin
        if (r_we) store[r_addr] <= r_wbyte;
        if (l_we) store[l_addr] <= l_wbyte;
    end

    // registered reads see the contents before this edge's writes
    always_ff @(posedge clk) begin
        if (rst) begin
            l_rbyte <= '0;
            l_rvld  <= 1'b0;
            r_rbyte <= '0;
            r_rvld  <= 1'b0;
        end else begin
            l_rbyte <= l_re ? store[l_addr] : '0;
            l_rvld  <= l_re;
            r_rbyte <= r_re ? store[r_addr] : '0;
            r_rvld  <= r_re;
        end
    end

endmodule

// File: rtl/dual_port_byte_ram.sv
module dual_port_byte_ram
    import dpram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel_n,
    input  logic              l_oe_n,
    input  logic              l_rw_lo,
    input  logic              l_rw_hi,
    input  logic              l_busy_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] l_rdata,
    output logic [LANES-1:0]  l_rvalid,
    input  logic              r_sel_n,
    input  logic              r_oe_n,
    input  logic              r_rw_lo,
    input  logic              r_rw_hi,
    input  logic              r_busy_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [WORD_W-1:0] r_wdata,
    output logic [WORD_W-1:0] r_rdata,
    output logic [LANES-1:0]  r_rvalid
);

    lane_cmd_t        l_cmd, r_cmd;
    logic [LANES-1:0] l_rw, r_rw;

    assign l_rw = {l_rw_hi, l_rw_lo};
    assign r_rw = {r_rw_hi, r_rw_lo};

    dpram_port_ctl u_lctl (
        .sel_n (l_sel_n),
        .oe_n  (l_oe_n),
        .busy_n(l_busy_n),
        .rw    (l_rw),
        .cmd   (l_cmd)
    );

    dpram_port_ctl u_rctl (
        .sel_n (r_sel_n),
        .oe_n  (r_oe_n),
        .busy_n(r_busy_n),
        .rw    (r_rw),
        .cmd   (r_cmd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpram_lane_bank #(
            .DEPTH (DEPTH),
            .ADDR_W(ADDR_W),
            .LANE_W(LANE_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .l_we   (l_cmd.we[g]),
            .l_re   (l_cmd.re[g]),
            .l_addr (l_addr),
            .l_wbyte(l_wdata[g*LANE_W +: LANE_W]),
            .r_we   (r_cmd.we[g]),
            .r_re   (r_cmd.re[g]),
            .r_addr (r_addr),
            .r_wbyte(r_wdata[g*LANE_W +: LANE_W]),
            .l_rbyte(l_rdata[g*LANE_W +: LANE_W]),
            .l_rvld (l_rvalid[g]),
            .r_rbyte(r_rdata[g*LANE_W +: LANE_W]),
            .r_rvld (r_rvalid[g])
        );
    end

endmodule

// File: rtl/dpram_chk.sv
module dpram_chk
    import dpram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              l_sel_n,
    input logic              l_oe_n,
    input logic              l_rw_hi,
    input logic [WORD_W-1:0] l_rdata,
    input logic [LANES-1:0]  l_rvalid,
    input logic              r_sel_n,
    input logic              r_oe_n,
    input logic              r_rw_lo,
    input logic [WORD_W-1:0] r_rdata,
    input logic [LANES-1:0]  r_rvalid
);

    // R2
    l_desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        l_sel_n |=> (l_rvalid == '0));

    // R2
    r_desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        r_sel_n |=> (r_rvalid == '0));

    // R5
    l_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        l_oe_n |=> (l_rvalid == '0));

    // R3
    l_write_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_sel_n && !l_rw_hi) |=> !l_rvalid[1]);

    // R4
    r_valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        r_rvalid[0] |-> $past(!r_sel_n && r_rw_lo && !r_oe_n));

    for (genvar g = 0; g < LANES; g++) begin : g_zero
        // R11
        l_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !l_rvalid[g] |-> (l_rdata[g*LANE_W +: LANE_W] == '0));
        // R11
        r_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !r_rvalid[g] |-> (r_rdata[g*LANE_W +: LANE_W] == '0));
    end

endmodule

bind dual_port_byte_ram dpram_chk i_dpram_chk (
    .clk     (clk),
    .rst     (rst),
    .l_sel_n (l_sel_n),
    .l_oe_n  (l_oe_n),
    .l_rw_hi (l_rw_hi),
    .l_rdata (l_rdata),
    .l_rvalid(l_rvalid),
    .r_sel_n (r_sel_n),
    .r_oe_n  (r_oe_n),
    .r_rw_lo (r_rw_lo),
    .r_rdata (r_rdata),
    .r_rvalid(r_rvalid)
);

// File: tb/test_dual_port_byte_ram.sv
`timescale 1ns/1ps
module test_dual_port_byte_ram;

    typedef struct packed {
        logic        sel_n;
        logic        oe_n;
        logic        rw_hi;
        logic        rw_lo;
        logic        busy_n;
        logic [10:0] addr;
        logic [15:0] wdata;
    } stim_t;

    typedef struct packed {
        stim_t       l;
        stim_t       r;
        logic [1:0]  lv;
        logic [15:0] ld;
        logic [1:0]  rv;
        logic [15:0] rd;
        logic [3:0]  req;
    } vec_t;

    function automatic stim_t S(logic sel_n, logic oe_n, logic rw_hi, logic rw_lo,
                                logic busy_n, logic [10:0] addr, logic [15:0] wdata);
        return {sel_n, oe_n, rw_hi, rw_lo, busy_n, addr, wdata};
    endfunction

    localparam stim_t IDLE = {5'b11111, 11'h0, 16'h0};
    localparam int NV = 14;

    localparam vec_t TBL [NV] = '{
        '{S(0,1,0,0,1,11'h000,16'hA1B2), IDLE,                          2'b00,16'h0000, 2'b00,16'h0000, 4'd3},  // R3
        '{S(0,0,1,1,1,11'h000,16'h0),    S(0,1,0,0,1,11'h7FF,16'hC3D4), 2'b11,16'hA1B2, 2'b00,16'h0000, 4'd4},  // R4 R1
        '{S(0,0,1,0,1,11'h7FF,16'h9955), S(0,0,1,1,1,11'h7FF,16'h0),    2'b10,16'hC300, 2'b11,16'hC3D4, 4'd9},  // R9 R6 R11
        '{IDLE,                          S(0,0,1,1,1,11'h7FF,16'h0),    2'b00,16'h0000, 2'b11,16'hC355, 4'd6},  // R6 R1
        '{S(0,1,0,0,0,11'h000,16'hFFFF), S(0,1,0,0,1,11'h001,16'h1234), 2'b00,16'h0000, 2'b00,16'h0000, 4'd7},  // R7
        '{S(0,0,1,1,1,11'h000,16'h0),    S(0,0,1,1,1,11'h001,16'h0),    2'b11,16'hA1B2, 2'b11,16'h1234, 4'd7},  // R7
        '{S(0,1,1,1,1,11'h000,16'h0),    S(1,0,0,0,1,11'h001,16'h0000), 2'b00,16'h0000, 2'b00,16'h0000, 4'd5},  // R5 R2
        '{S(0,0,1,1,1,11'h001,16'h0),    S(0,0,1,1,1,11'h000,16'h0),    2'b11,16'h1234, 2'b11,16'hA1B2, 4'd2},  // R2
        '{S(0,1,0,0,1,11'h010,16'h1111), S(0,1,0,0,1,11'h010,16'h2222), 2'b00,16'h0000, 2'b00,16'h0000, 4'd8},  // R8
        '{S(0,1,0,1,1,11'h020,16'hAA00), S(0,1,1,0,1,11'h020,16'h00BB), 2'b00,16'h0000, 2'b00,16'h0000, 4'd8},  // R8
        '{S(0,0,1,1,1,11'h010,16'h0),    S(0,0,1,1,1,11'h020,16'h0),    2'b11,16'h1111, 2'b11,16'hAABB, 4'd8},  // R8
        '{S(0,1,0,0,1,11'h030,16'h5A5A), S(0,0,1,1,0,11'h7FF,16'h0),    2'b00,16'h0000, 2'b11,16'hC355, 4'd7},  // R7 R5
        '{S(0,0,1,1,1,11'h030,16'h0),    IDLE,                          2'b11,16'h5A5A, 2'b00,16'h0000, 4'd5},  // R5
        '{IDLE,                          IDLE,                          2'b00,16'h0000, 2'b00,16'h0000, 4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    stim_t       ls = IDLE;
    stim_t       rs = IDLE;
    logic [15:0] l_rdata, r_rdata;
    logic [1:0]  l_rvalid, r_rvalid;
    int          tests = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    dual_port_byte_ram i_dual_port_byte_ram (
        .clk     (clk),
        .rst     (rst),
        .l_sel_n (ls.sel_n),
        .l_oe_n  (ls.oe_n),
        .l_rw_lo (ls.rw_lo),
        .l_rw_hi (ls.rw_hi),
        .l_busy_n(ls.busy_n),
        .l_addr  (ls.addr),
        .l_wdata (ls.wdata),
        .l_rdata (l_rdata),
        .l_rvalid(l_rvalid),
        .r_sel_n (rs.sel_n),
        .r_oe_n  (rs.oe_n),
        .r_rw_lo (rs.rw_lo),
        .r_rw_hi (rs.rw_hi),
        .r_busy_n(rs.busy_n),
        .r_addr  (rs.addr),
        .r_wdata (rs.wdata),
        .r_rdata (r_rdata),
        .r_rvalid(r_rvalid)
    );

    task automatic chk(input string side, input int req,
                       input logic [1:0] av, input logic [15:0] ad,
                       input logic [1:0] ev, input logic [15:0] ed);
        tests++;
        if (av !== ev || ad !== ed) begin
            fails++;
            $display("FAIL R%0d %s port: valid=%b data=%h, expected valid=%b data=%h",
                     req, side, av, ad, ev, ed);
        end
    endtask

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: outputs cleared by reset
        chk("left",  10, l_rvalid, l_rdata, 2'b00, 16'h0);
        chk("right", 10, r_rvalid, r_rdata, 2'b00, 16'h0);

        for (int i = 0; i < NV; i++) begin
            ls = TBL[i].l;
            rs = TBL[i].r;
            @(negedge clk);
            chk("left",  int'(TBL[i].req), l_rvalid, l_rdata, TBL[i].lv, TBL[i].ld);
            chk("right", int'(TBL[i].req), r_rvalid, r_rdata, TBL[i].rv, TBL[i].rd);
        end

        // R10: reset mid-run clears a pending read result, memory survives
        ls = S(0,0,1,1,1,11'h000,16'h0);
        @(negedge clk);
        chk("left", 4, l_rvalid, l_rdata, 2'b11, 16'hA1B2);
        rst = 1'b1;
        @(negedge clk);
        chk("left", 10, l_rvalid, l_rdata, 2'b00, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("left", 10, l_rvalid, l_rdata, 2'b11, 16'hA1B2);
        ls = IDLE;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule